// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of instructions in a speculative out-of-order core. Each instruction that issues takes the entry at the tail of a circular buffer. The buffer records the operation code, the destination register and whether the instruction is a branch, and it marks the entry as waiting. Execution units finish in any order. Each one broadcasts its result together with the index of its entry, and the buffer stores the value and marks the entry as done. Issue logic can look up any entry by index and take its value once that value is present.

Retirement happens only at the head and only when the head entry has its result. It happens at most once per cycle. For an ordinary instruction, the commit port presents the destination, the value, the operation and the entry index, so that register status logic can compare the index against its rename tag. A branch whose prediction held leaves the buffer silently. A branch that was mispredicted empties the whole buffer in one step and presents the correct fetch address, which that branch carried as its result value.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, and commit_valid and flush_valid are 0.
- R2: Each accepted allocation (alloc_valid and alloc_ready both high at a clock edge) takes the index shown on alloc_tag. alloc_tag then advances by one, wrapping from DEPTH-1 to 0.
- R3: With DEPTH entries occupied, alloc_ready is 0, and an allocation request changes neither alloc_tag nor any entry.
- R4: A freshly allocated entry reads as not ready (rd_ready = 0) on the read port until a result for it arrives.
- R5: A result broadcast (cdb_valid with cdb_tag naming an occupied entry) makes that entry read rd_ready = 1 with rd_value equal to cdb_value from the next cycle on.
- R6: A result broadcast to an unoccupied entry is ignored: the read port still shows rd_ready = 0 for that index.
- R7: Nothing retires while the head entry lacks its result, even if younger entries have theirs.
- R8: Retirement is in order, one entry per cycle. When the head holds a ready non-branch instruction, commit_valid is 1 with commit_tag, commit_op, commit_dest and commit_value taken from that entry. The entry leaves at the next clock edge.
- R9: A ready branch at the head whose cdb_mispredict was 0 leaves without raising commit_valid or flush_valid. The next entry may retire in the following cycle.
- R10: A ready branch at the head whose cdb_mispredict was 1 raises flush_valid with flush_target equal to its stored result value, and commit_valid stays 0. At the next edge every entry is freed and the head and tail return to index 0.
- R11: During a flush cycle alloc_ready is 0, and an allocation request in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate an entry at the tail |
| alloc_op | input | OP_W | Operation code to record |
| alloc_dest | input | REG_W | Destination architectural register |
| alloc_is_branch | input | 1 | The instruction is a branch |
| alloc_ready | output | 1 | An allocation request is accepted this cycle |
| alloc_tag | output | TAG_W | Index the next allocation receives |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Entry index of the result |
| cdb_value | input | DATA_W | Result value, or the correct target for a branch |
| cdb_mispredict | input | 1 | For a branch: the prediction was wrong |
| rd_tag | input | TAG_W | Index looked up by issue logic |
| rd_ready | output | 1 | The looked-up entry is occupied and has its result |
| rd_value | output | DATA_W | Result value of the looked-up entry |
| commit_valid | output | 1 | Head non-branch retires this cycle |
| commit_tag | output | TAG_W | Index of the retiring entry |
| commit_op | output | OP_W | Operation code of the retiring entry |
| commit_dest | output | REG_W | Destination register to write |
| commit_value | output | DATA_W | Value to write |
| flush_valid | output | 1 | Mispredicted branch retires; the buffer empties at the next edge |
| flush_target | output | DATA_W | Correct fetch address |

## Verification
The bench builds the block with its defaults: eight entries, 32-bit values, 6-bit operation codes and 5-bit register indices. With eight entries a fill from a non-zero head is short, so one scenario covers pointer wraparound, the full stall and an ignored request while full. Out-of-order results behind an unready head, a flush taken while the buffer is nearly full, and an allocation dropped in the flush cycle are all reached in a few dozen cycles.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    RET_NONE   = 2'd0,
    RET_WRITE  = 2'd1,
    RET_BR_OK  = 2'd2,
    RET_FLUSH  = 2'd3
  } retire_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  logic [TAG_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] count_d;

  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head_d  = head;
    tail_d  = tail;
    count_d = count;
    if (flush) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
    end else begin
      if (alloc_fire)  tail_d = step(tail);
      if (retire_fire) head_d = step(head);
      case ({alloc_fire, retire_fire})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head_d;
      tail  <= tail_d;
      count <= count_d;
    end
  end

  assign full = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/rob_entry.sv
module rob_entry #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 6,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_hit,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              alloc_is_branch,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_value,
  input  logic              wr_mispredict,
  input  logic              retire_hit,
  input  logic              clear_all,
  output logic              busy,
  output logic              ready,
  output logic              is_branch,
  output logic              mispredict,
  output logic [OP_W-1:0]   op,
  output logic [REG_W-1:0]  dest,
  output logic [DATA_W-1:0] value
);

  logic busy_d, ready_d;
  logic wr_take;

  assign wr_take = wr_hit && busy && !alloc_hit;

  always_comb begin
    busy_d  = busy;
    ready_d = ready;
    if (clear_all) begin
      busy_d  = 1'b0;
      ready_d = 1'b0;
    end else if (alloc_hit) begin
      busy_d  = 1'b1;
      ready_d = 1'b0;
    end else if (retire_hit) begin
      busy_d  = 1'b0;
      ready_d = 1'b0;
    end else if (wr_take) begin
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ready <= 1'b0;
    end else begin
      busy  <= busy_d;
      ready <= ready_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_hit) begin
      op        <= alloc_op;
      dest      <= alloc_dest;
      is_branch <= alloc_is_branch;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) begin
      value      <= wr_value;
      mispredict <= wr_mispredict;
    end
  end

endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
(
  input  logic    head_busy,
  input  logic    head_ready,
  input  logic    head_is_branch,
  input  logic    head_mispredict,
  output retire_e kind
);

  always_comb begin
    kind = RET_NONE;
    if (head_busy && head_ready) begin
      if (!head_is_branch)      kind = RET_WRITE;
      else if (head_mispredict) kind = RET_FLUSH;
      else                      kind = RET_BR_OK;
    end
  end

endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int OP_W   = 6,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              alloc_is_branch,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispredict,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_value,
  output logic              commit_valid,
  output logic [TAG_W-1:0]  commit_tag,
  output logic [OP_W-1:0]   commit_op,
  output logic [REG_W-1:0]  commit_dest,
  output logic [DATA_W-1:0] commit_value,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_target
);

  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full;
  logic             alloc_fire, retire_fire, flush;
  retire_e          kind;

  logic [DEPTH-1:0] busy_v, ready_v, br_v, mis_v;
  logic [OP_W-1:0]   op_a  [DEPTH];
  logic [REG_W-1:0]  dst_a [DEPTH];
  logic [DATA_W-1:0] val_a [DEPTH];

  assign alloc_ready = !full && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_fire),
    .flush       (flush),
    .head        (head),
    .tail        (tail),
    .count       (count),
    .full        (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    rob_entry #(.DATA_W(DATA_W), .OP_W(OP_W), .REG_W(REG_W)) u_ent (
      .clk             (clk),
      .rst_n           (rst_n),
      .alloc_hit       (alloc_fire && (tail == TAG_W'(i))),
      .alloc_op        (alloc_op),
      .alloc_dest      (alloc_dest),
      .alloc_is_branch (alloc_is_branch),
      .wr_hit          (cdb_valid && (cdb_tag == TAG_W'(i))),
      .wr_value        (cdb_value),
      .wr_mispredict   (cdb_mispredict),
      .retire_hit      (retire_fire && (head == TAG_W'(i))),
      .clear_all       (flush),
      .busy            (busy_v[i]),
      .ready           (ready_v[i]),
      .is_branch       (br_v[i]),
      .mispredict      (mis_v[i]),
      .op              (op_a[i]),
      .dest            (dst_a[i]),
      .value           (val_a[i])
    );
  end

  rob_retire u_retire (
    .head_busy       (busy_v[head]),
    .head_ready      (ready_v[head]),
    .head_is_branch  (br_v[head]),
    .head_mispredict (mis_v[head]),
    .kind            (kind)
  );

  assign retire_fire  = (kind != RET_NONE);
  assign flush        = (kind == RET_FLUSH);

  assign commit_valid = (kind == RET_WRITE);
  assign commit_tag   = head;
  assign commit_op    = op_a[head];
  assign commit_dest  = dst_a[head];
  assign commit_value = val_a[head];
  assign flush_valid  = flush;
  assign flush_target = val_a[head];

  assign rd_ready = busy_v[rd_tag] && ready_v[rd_tag];
  assign rd_value = val_a[rd_tag];

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             commit_valid,
  input logic [TAG_W-1:0] commit_tag,
  input logic             flush_valid,
  input logic [CNT_W-1:0] count
);

  logic [TAG_W-1:0] alloc_nxt, commit_nxt, alloc_prev, commit_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_prev  <= '0;
      commit_prev <= '0;
    end else begin
      alloc_prev  <= alloc_tag;
      commit_prev <= commit_tag;
    end
  end

  assign alloc_nxt  = (alloc_prev  == TAG_W'(DEPTH - 1)) ? '0 : alloc_prev  + 1'b1;
  assign commit_nxt = (commit_prev == TAG_W'(DEPTH - 1)) ? '0 : commit_prev + 1'b1;

  assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_tag == alloc_nxt));

  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !alloc_ready);

  assert_empty_no_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (!commit_valid && !flush_valid));

  assert_inorder_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> (!commit_valid || commit_tag == commit_nxt));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_valid, flush_valid}));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (count == '0 && !commit_valid && !flush_valid));

  assert_flush_blocks_alloc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !alloc_ready);

endmodule

bind rob_top rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .alloc_tag    (alloc_tag),
  .commit_valid (commit_valid),
  .commit_tag   (commit_tag),
  .flush_valid  (flush_valid),
  .count        (count)
);

// File: tb/tb_rob_top.sv
`timescale 1ns/1ps
module tb_rob_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid;
  logic [5:0]  alloc_op;
  logic [4:0]  alloc_dest;
  logic        alloc_is_branch;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [31:0] cdb_value;
  logic        cdb_mispredict;
  logic [2:0]  rd_tag;
  logic        rd_ready;
  logic [31:0] rd_value;
  logic        commit_valid;
  logic [2:0]  commit_tag;
  logic [5:0]  commit_op;
  logic [4:0]  commit_dest;
  logic [31:0] commit_value;
  logic        flush_valid;
  logic [31:0] flush_target;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rob_top dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle();
    @(posedge clk); #2;
  endtask

  task automatic do_alloc(input logic [5:0] op, input logic [4:0] dst,
                          input logic br, output logic [2:0] tag);
    alloc_valid = 1'b1; alloc_op = op; alloc_dest = dst; alloc_is_branch = br;
    #1 tag = alloc_tag;
    @(posedge clk); #1 alloc_valid = 1'b0; #1;
  endtask

  task automatic do_cdb(input logic [2:0] tag, input logic [31:0] val, input logic mis);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_value = val; cdb_mispredict = mis;
    @(posedge clk); #1 cdb_valid = 1'b0; #1;
  endtask

  task automatic peek(input logic [2:0] tag);
    rd_tag = tag; #1;
  endtask

  task automatic t_reset();
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 alloc_tag", alloc_tag, 0);
    check("R1 commit_valid", commit_valid, 0);
    check("R1 flush_valid", flush_valid, 0);
  endtask

  task automatic t_inorder();
    logic [2:0] t;
    for (int i = 0; i < 3; i++) begin
      do_alloc(6'(10 + i), 5'(3 + i), 1'b0, t);
      check("R2 tag sequence", t, i);
    end
    peek(3'd1);
    check("R4 new entry not ready", rd_ready, 0);
    do_cdb(3'd2, 32'hC2, 1'b0);
    check("R7 no retire behind head", commit_valid, 0);
    peek(3'd2);
    check("R5 rd_ready", rd_ready, 1);
    check("R5 rd_value", rd_value, 32'hC2);
    do_cdb(3'd1, 32'hC1, 1'b0);
    check("R7 still waiting", commit_valid, 0);
    do_cdb(3'd0, 32'hC0, 1'b0);
    check("R8 commit_valid t0", commit_valid, 1);
    check("R8 commit_tag t0", commit_tag, 0);
    check("R8 commit_dest t0", commit_dest, 3);
    check("R8 commit_op t0", commit_op, 10);
    check("R8 commit_value t0", commit_value, 32'hC0);
    idle();
    check("R8 commit_tag t1", commit_tag, 1);
    check("R8 commit_value t1", commit_value, 32'hC1);
    idle();
    check("R8 commit_tag t2", commit_tag, 2);
    check("R8 commit_dest t2", commit_dest, 5);
    idle();
    check("R8 drained", commit_valid, 0);
    peek(3'd2);
    check("R8 retired entry freed", rd_ready, 0);
  endtask

  task automatic t_full_flush();
    logic [2:0] t;
    do_cdb(3'd6, 32'hDEAD, 1'b0);
    peek(3'd6);
    check("R6 free entry ignores result", rd_ready, 0);
    for (int i = 0; i < 8; i++) begin
      check("R3 ready before full", alloc_ready, 1);
      do_alloc(6'(20 + i), 5'(8 + i), (i == 1), t);
      check("R2 wrap tag", t, (3 + i) % 8);
    end
    check("R3 full stalls", alloc_ready, 0);
    alloc_valid = 1'b1; alloc_op = 6'd63; alloc_dest = 5'd31; alloc_is_branch = 1'b0;
    idle();
    alloc_valid = 1'b0;
    check("R3 tag unchanged when full", alloc_tag, 3);
    check("R3 still full", alloc_ready, 0);
    do_cdb(3'd5, 32'h55, 1'b0);
    do_cdb(3'd4, 32'h100, 1'b1);
    check("R7 head not ready", commit_valid, 0);
    check("R7 no flush yet", flush_valid, 0);
    do_cdb(3'd3, 32'h33, 1'b0);
    check("R8 commit before branch", commit_valid, 1);
    check("R8 commit_dest head", commit_dest, 8);
    check("R3 full untouched by blocked request", commit_op, 20);
    alloc_valid = 1'b1; alloc_op = 6'd1; alloc_dest = 5'd1; alloc_is_branch = 1'b0;
    idle();
    check("R10 flush_valid", flush_valid, 1);
    check("R10 flush_target", flush_target, 32'h100);
    check("R10 no commit on flush", commit_valid, 0);
    check("R11 alloc blocked in flush", alloc_ready, 0);
    @(posedge clk); #1 alloc_valid = 1'b0; #1;
    check("R10 flush done", flush_valid, 0);
    check("R10 tail reset", alloc_tag, 0);
    check("R10 ready after flush", alloc_ready, 1);
    peek(3'd5);
    check("R10 entries cleared", rd_ready, 0);
    do_cdb(3'd0, 32'hBEEF, 1'b0);
    peek(3'd0);
    check("R11 dropped alloc left entry free", rd_ready, 0);
  endtask

  task automatic t_branch_ok();
    logic [2:0] t;
    do_alloc(6'd40, 5'd0, 1'b1, t);
    check("R2 tag after flush", t, 0);
    do_alloc(6'd41, 5'd7, 1'b0, t);
    do_cdb(3'd1, 32'h77, 1'b0);
    check("R7 branch not resolved", commit_valid, 0);
    do_cdb(3'd0, 32'h200, 1'b0);
    check("R9 no commit for branch", commit_valid, 0);
    check("R9 no flush for branch", flush_valid, 0);
    idle();
    check("R9 next entry commits", commit_valid, 1);
    check("R9 next tag", commit_tag, 1);
    check("R9 next value", commit_value, 32'h77);
    idle();
    check("R9 drained", commit_valid, 0);
    check("R9 tail", alloc_tag, 2);
  endtask

  initial begin
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_op = '0; alloc_dest = '0; alloc_is_branch = 1'b0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0; cdb_mispredict = 1'b0;
    rd_tag = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_inorder();
    t_full_flush();
    t_branch_ok();
    finish_run();
  end

  initial begin
    #500us;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

endmodule